// File: doc/BRIEF.md
# Shared Address/Data Bus Demultiplexer

This block connects a processor whose low address bits and data bits share one set of pins to a system of memories and I/O devices, which need a stable address, separate commands and a data path that points one way. At the start of each access the processor places the address on the shared pins and pulses an address strobe. The block passes the address through while the strobe is high. When the strobe falls, it freezes the address and keeps driving it for the rest of the cycle, so the shared pins are free to carry data.

A memory/IO select and two active-low strobes, one for read and one for write, are decoded into four active-low commands: memory read, memory write, I/O read and I/O write. If both strobes are low at once, the block asserts no command and raises an error flag. The data path has separate input, output and output-enable signals on each side. A transmit/receive pin chooses whether processor data goes out to the system or system data comes back to the processor. Neither side is driven unless exactly one strobe is active.

Top module: `busdmx_top`

## Requirements
- R1: While `cpu_ale_i` is high, `sys_addr_o` equals `{cpu_hi_addr_i, cpu_ad_i}` in the same cycle.
- R2: After `cpu_ale_i` falls, `sys_addr_o` holds the value that was on `{cpu_hi_addr_i, cpu_ad_i}` at the last rising clock edge with `cpu_ale_i` high. Later changes on those inputs have no effect on it until `cpu_ale_i` rises again.
- R3: The upper address bits `cpu_hi_addr_i` are captured by the same strobe and the same edge as the low bits. `sys_addr_o[19:16]` therefore freezes together with `sys_addr_o[15:0]`.
- R4: With exactly one strobe low, decoding works as follows. `cpu_rd_n_i`=0 with `cpu_mio_i`=1 drives `mem_rd_n_o`=0. `cpu_rd_n_i`=0 with `cpu_mio_i`=0 drives `io_rd_n_o`=0. `cpu_wr_n_i`=0 with `cpu_mio_i`=1 drives `mem_wr_n_o`=0. `cpu_wr_n_i`=0 with `cpu_mio_i`=0 drives `io_wr_n_o`=0. All other commands stay at 1.
- R5: At most one of the four command outputs is low at any time, and all four are high when both strobes are high.
- R6: When `cpu_rd_n_i` and `cpu_wr_n_i` are both low, all four commands stay high and `proto_err_o` is 1. Otherwise `proto_err_o` is 0.
- R7: With exactly one strobe low and `cpu_dtr_i`=1, the outputs are `sys_data_oe_o`=1, `sys_data_o`=`cpu_ad_i` and `cpu_ad_oe_o`=0.
- R8: With exactly one strobe low and `cpu_dtr_i`=0, the outputs are `cpu_ad_oe_o`=1, `cpu_ad_o`=`sys_data_i` and `sys_data_oe_o`=0.
- R9: When neither strobe is low, or both are low, both output enables are 0 and both data outputs are 0.
- R10: After reset, with `cpu_ale_i` low, `sys_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_ad_i | input | 16 | Shared address/data pins, processor side, inbound |
| cpu_ad_o | output | 16 | Data returned to the processor |
| cpu_ad_oe_o | output | 1 | Enable for driving `cpu_ad_o` onto the shared pins |
| cpu_hi_addr_i | input | 4 | Upper address bits from the processor |
| cpu_ale_i | input | 1 | Address strobe, active high |
| cpu_mio_i | input | 1 | 1 = memory access, 0 = I/O access |
| cpu_rd_n_i | input | 1 | Read strobe, active low |
| cpu_wr_n_i | input | 1 | Write strobe, active low |
| cpu_dtr_i | input | 1 | 1 = data goes outward to the system, 0 = data comes inward to the processor |
| sys_addr_o | output | 20 | Address presented to the system |
| sys_data_i | input | 16 | Data from the system devices |
| sys_data_o | output | 16 | Data to the system devices |
| sys_data_oe_o | output | 1 | Enable for driving `sys_data_o` |
| mem_rd_n_o | output | 1 | Memory read command, active low |
| mem_wr_n_o | output | 1 | Memory write command, active low |
| io_rd_n_o | output | 1 | I/O read command, active low |
| io_wr_n_o | output | 1 | I/O write command, active low |
| proto_err_o | output | 1 | Both strobes low at once |

## Verification
The address assertions assume that the bus inputs change only away from the rising clock edge. They also assume that the address strobe stays low while reset is held, so the frozen value is always one sampled at a clock edge. The bench meets both conditions by changing every input just after a falling edge and holding the strobe low through reset. The command and steering properties make no assumption about the order of the strobes, so the bench drives every strobe and select combination, including the illegal one where both strobes are low.

// File: rtl/busdmx_pkg.sv
package busdmx_pkg;

  typedef enum logic [1:0] {
    XFER_IDLE  = 2'd0,
    XFER_READ  = 2'd1,
    XFER_WRITE = 2'd2,
    XFER_CLASH = 2'd3
  } xfer_e;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
  } cmd_t;

  function automatic xfer_e classify(input logic rd_n, input logic wr_n);
    xfer_e k;
    case ({rd_n, wr_n})
      2'b11:   k = XFER_IDLE;
      2'b01:   k = XFER_READ;
      2'b10:   k = XFER_WRITE;
      default: k = XFER_CLASH;
    endcase
    return k;
  endfunction

  function automatic cmd_t decode(input xfer_e k, input logic is_mem);
    cmd_t c;
    c = '0;
    c.mem_rd = (k == XFER_READ)  &&  is_mem;
    c.io_rd  = (k == XFER_READ)  && !is_mem;
    c.mem_wr = (k == XFER_WRITE) &&  is_mem;
    c.io_wr  = (k == XFER_WRITE) && !is_mem;
    return c;
  endfunction

endpackage

// File: rtl/busdmx_addr_latch.sv
module busdmx_addr_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] addr_o
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  held_q <= '0;
    else if (le) held_q <= bus_i;
  end

  // Pass-through while the strobe is open, held copy once it closes.
  assign addr_o = le ? bus_i : held_q;
endmodule

// File: rtl/busdmx_cmd_decode.sv
module busdmx_cmd_decode
  import busdmx_pkg::*;
(
  input  logic  rd_n,
  input  logic  wr_n,
  input  logic  is_mem,
  output xfer_e kind_o,
  output logic  [3:0] cmd_n_o,
  output logic  clash_o
);
  cmd_t cmd;

  always_comb begin
    kind_o = classify(rd_n, wr_n);
    cmd    = decode(kind_o, is_mem);
  end

  assign cmd_n_o = ~{cmd.mem_rd, cmd.mem_wr, cmd.io_rd, cmd.io_wr};
  assign clash_o = (kind_o == XFER_CLASH);
endmodule

// File: rtl/busdmx_data_steer.sv
module busdmx_data_steer
  import busdmx_pkg::*;
#(
  parameter int W = 16
) (
  input  xfer_e        kind,
  input  logic         outward,
  input  logic [W-1:0] cpu_i,
  input  logic [W-1:0] sys_i,
  output logic [W-1:0] cpu_o,
  output logic         cpu_oe_o,
  output logic [W-1:0] sys_o,
  output logic         sys_oe_o
);
  logic active;

  assign active   = (kind == XFER_READ) || (kind == XFER_WRITE);
  assign sys_oe_o = active &&  outward;
  assign cpu_oe_o = active && !outward;
  assign sys_o    = sys_oe_o ? cpu_i : '0;
  assign cpu_o    = cpu_oe_o ? sys_i : '0;
endmodule

// File: rtl/busdmx_top.sv
module busdmx_top
  import busdmx_pkg::*;
#(
  parameter int LO_W = 16,
  parameter int HI_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LO_W-1:0]      cpu_ad_i,
  output logic [LO_W-1:0]      cpu_ad_o,
  output logic                 cpu_ad_oe_o,
  input  logic [HI_W-1:0]      cpu_hi_addr_i,
  input  logic                 cpu_ale_i,
  input  logic                 cpu_mio_i,
  input  logic                 cpu_rd_n_i,
  input  logic                 cpu_wr_n_i,
  input  logic                 cpu_dtr_i,
  output logic [LO_W+HI_W-1:0] sys_addr_o,
  input  logic [LO_W-1:0]      sys_data_i,
  output logic [LO_W-1:0]      sys_data_o,
  output logic                 sys_data_oe_o,
  output logic                 mem_rd_n_o,
  output logic                 mem_wr_n_o,
  output logic                 io_rd_n_o,
  output logic                 io_wr_n_o,
  output logic                 proto_err_o
);
  localparam int ADDR_W = LO_W + HI_W;

  xfer_e      kind;
  logic [3:0] cmd_n;
  logic       clash;
  // Named events for the checker
  logic       addr_capture;
  logic       addr_freeze;
  logic       ale_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ale_q <= 1'b0;
    else        ale_q <= cpu_ale_i;
  end
  assign addr_capture = cpu_ale_i;
  assign addr_freeze  = ale_q && !cpu_ale_i;

  busdmx_addr_latch #(.W(LO_W)) u_lo_latch (
    .clk(clk), .rst_n(rst_n), .le(cpu_ale_i),
    .bus_i(cpu_ad_i), .addr_o(sys_addr_o[LO_W-1:0])
  );

  busdmx_addr_latch #(.W(HI_W)) u_hi_latch (
    .clk(clk), .rst_n(rst_n), .le(cpu_ale_i),
    .bus_i(cpu_hi_addr_i), .addr_o(sys_addr_o[ADDR_W-1:LO_W])
  );

  busdmx_cmd_decode u_dec (
    .rd_n(cpu_rd_n_i), .wr_n(cpu_wr_n_i), .is_mem(cpu_mio_i),
    .kind_o(kind), .cmd_n_o(cmd_n), .clash_o(clash)
  );

  assign {mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o} = cmd_n;
  assign proto_err_o = clash;

  busdmx_data_steer #(.W(LO_W)) u_steer (
    .kind(kind), .outward(cpu_dtr_i),
    .cpu_i(cpu_ad_i), .sys_i(sys_data_i),
    .cpu_o(cpu_ad_o), .cpu_oe_o(cpu_ad_oe_o),
    .sys_o(sys_data_o), .sys_oe_o(sys_data_oe_o)
  );
endmodule

// File: rtl/busdmx_checker.sv
module busdmx_checker #(
  parameter int LO_W = 16,
  parameter int HI_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [LO_W-1:0]      ad_i,
  input logic [HI_W-1:0]      hi_i,
  input logic                 rd_n,
  input logic                 wr_n,
  input logic                 dtr,
  input logic [LO_W+HI_W-1:0] addr_o,
  input logic [3:0]           cmd_n,
  input logic                 err,
  input logic                 cpu_oe,
  input logic                 sys_oe,
  input logic [LO_W-1:0]      cpu_d_o,
  input logic [LO_W-1:0]      sys_d_o,
  input logic [LO_W-1:0]      sys_d_i,
  input logic                 capture,
  input logic                 freeze
);
  p_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> addr_o == {hi_i, ad_i});

  // R2 and R3: the whole address, upper bits included, freezes on one edge
  p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> addr_o == $past({hi_i, ad_i}));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !freeze) |-> $stable(addr_o));

  p_one_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cmd_n) <= 1);

  p_idle_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n) |-> (cmd_n == 4'hF && !err));

  p_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !wr_n) |-> (cmd_n == 4'hF && err));

  p_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_n != wr_n) && dtr) |-> (sys_oe && !cpu_oe && sys_d_o == ad_i));

  p_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_n != wr_n) && !dtr) |-> (cpu_oe && !sys_oe && cpu_d_o == sys_d_i));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n == wr_n) |-> (!cpu_oe && !sys_oe));
endmodule

bind busdmx_top busdmx_checker #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ad_i(cpu_ad_i), .hi_i(cpu_hi_addr_i),
  .rd_n(cpu_rd_n_i), .wr_n(cpu_wr_n_i), .dtr(cpu_dtr_i),
  .addr_o(sys_addr_o),
  .cmd_n({mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o}),
  .err(proto_err_o), .cpu_oe(cpu_ad_oe_o), .sys_oe(sys_data_oe_o),
  .cpu_d_o(cpu_ad_o), .sys_d_o(sys_data_o), .sys_d_i(sys_data_i),
  .capture(addr_capture), .freeze(addr_freeze)
);

// File: tb/busdmx_top_tb.sv
module busdmx_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_ad_i = '0;
  logic [15:0] cpu_ad_o;
  logic        cpu_ad_oe_o;
  logic [3:0]  cpu_hi_addr_i = '0;
  logic        cpu_ale_i = 1'b0;
  logic        cpu_mio_i = 1'b1;
  logic        cpu_rd_n_i = 1'b1;
  logic        cpu_wr_n_i = 1'b1;
  logic        cpu_dtr_i = 1'b0;
  logic [19:0] sys_addr_o;
  logic [15:0] sys_data_i = '0;
  logic [15:0] sys_data_o;
  logic        sys_data_oe_o;
  logic        mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o, proto_err_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busdmx_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_ad_i(cpu_ad_i), .cpu_ad_o(cpu_ad_o), .cpu_ad_oe_o(cpu_ad_oe_o),
    .cpu_hi_addr_i(cpu_hi_addr_i), .cpu_ale_i(cpu_ale_i), .cpu_mio_i(cpu_mio_i),
    .cpu_rd_n_i(cpu_rd_n_i), .cpu_wr_n_i(cpu_wr_n_i), .cpu_dtr_i(cpu_dtr_i),
    .sys_addr_o(sys_addr_o), .sys_data_i(sys_data_i), .sys_data_o(sys_data_o),
    .sys_data_oe_o(sys_data_oe_o), .mem_rd_n_o(mem_rd_n_o), .mem_wr_n_o(mem_wr_n_o),
    .io_rd_n_o(io_rd_n_o), .io_wr_n_o(io_wr_n_o), .proto_err_o(proto_err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive just after a falling edge and settle before sampling
  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    step(); #1;
    check("R10 address after reset", 32'(sys_addr_o), 32'h0);
    check("R5 idle commands", 32'({mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o}), 32'hF);
    check("R9 idle enables", 32'({cpu_ad_oe_o, sys_data_oe_o}), 32'h0);
  endtask

  task automatic t_latch(input logic [3:0] hi, input logic [15:0] lo, input int open_cycles);
    step();
    cpu_ale_i = 1'b1; cpu_hi_addr_i = hi; cpu_ad_i = lo;
    #1 check("R1 pass-through", 32'(sys_addr_o), 32'({hi, lo}));
    for (int i = 1; i < open_cycles; i++) step();
    step();
    cpu_ale_i = 1'b0; cpu_ad_i = ~lo; cpu_hi_addr_i = ~hi;
    #1 check("R2 frozen low bits", 32'(sys_addr_o[15:0]), 32'(lo));
    check("R3 frozen high bits", 32'(sys_addr_o[19:16]), 32'(hi));
    step(); step();
    cpu_ad_i = 16'h5A5A; cpu_hi_addr_i = 4'h3;
    #1 check("R2 later bus change ignored", 32'(sys_addr_o), 32'({hi, lo}));
  endtask

  task automatic t_decode(input logic mio, input logic rd_n, input logic wr_n, input logic [3:0] exp);
    step();
    cpu_mio_i = mio; cpu_rd_n_i = rd_n; cpu_wr_n_i = wr_n;
    #1 check("R4 command decode", 32'({mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o}), 32'(exp));
    check("R6 no error on single strobe", 32'(proto_err_o), 32'h0);
    step(); cpu_rd_n_i = 1'b1; cpu_wr_n_i = 1'b1;
    #1 check("R5 commands release", 32'({mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o}), 32'hF);
  endtask

  task automatic t_clash(input logic mio);
    step();
    cpu_mio_i = mio; cpu_rd_n_i = 1'b0; cpu_wr_n_i = 1'b0; cpu_dtr_i = 1'b1;
    cpu_ad_i = 16'h1234;
    #1 check("R6 clash no command", 32'({mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o}), 32'hF);
    check("R6 clash flag", 32'(proto_err_o), 32'h1);
    check("R9 clash no drive", 32'({cpu_ad_oe_o, sys_data_oe_o, sys_data_o}), 32'h0);
    step(); cpu_rd_n_i = 1'b1; cpu_wr_n_i = 1'b1;
    #1 check("R6 flag clears", 32'(proto_err_o), 32'h0);
  endtask

  task automatic t_steer(input logic [15:0] wdata, input logic [15:0] rdata);
    step();
    cpu_dtr_i = 1'b1; cpu_wr_n_i = 1'b0; cpu_ad_i = wdata; sys_data_i = rdata;
    #1 check("R7 outward data", 32'(sys_data_o), 32'(wdata));
    check("R7 outward enables", 32'({cpu_ad_oe_o, sys_data_oe_o}), 32'h1);
    step();
    cpu_wr_n_i = 1'b1; cpu_dtr_i = 1'b0; cpu_rd_n_i = 1'b0;
    #1 check("R8 inward data", 32'(cpu_ad_o), 32'(rdata));
    check("R8 inward enables", 32'({cpu_ad_oe_o, sys_data_oe_o}), 32'h2);
    step();
    cpu_rd_n_i = 1'b1;
    #1 check("R9 idle no drive", 32'({cpu_ad_oe_o, sys_data_oe_o, cpu_ad_o, sys_data_o}), 32'h0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latch(4'hA, 16'hC0DE, 1);
    t_latch(4'h5, 16'h0F0F, 3);
    t_latch(4'hF, 16'hFFFF, 2);
    t_decode(1'b1, 1'b0, 1'b1, 4'b0111);
    t_decode(1'b1, 1'b1, 1'b0, 4'b1011);
    t_decode(1'b0, 1'b0, 1'b1, 4'b1101);
    t_decode(1'b0, 1'b1, 1'b0, 4'b1110);
    t_clash(1'b1);
    t_clash(1'b0);
    t_steer(16'hBEEF, 16'h4321);
    t_steer(16'h0001, 16'h8000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule